// File: doc/BRIEF.md
# Low-Activity Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the full `2*WIDTH`-bit product. It works radix-2 and takes one multiplier bit per clock cycle. It is built to keep the number of flip-flops that toggle on each cycle low.

The multiplier operand is loaded once and is never shifted. A one-hot ring register marks the bit that is being retired, and its top position also marks completion, so no binary counter is needed. The multiplicand input drives the adder directly, with no register in between. On a zero multiplier bit the upper partial product takes a plain shift path and the adder result is not used. The lower half of the product is never shifted. Each retired bit is written once, into its final position, through a per-bit enable taken from the ring.

A caller pulses `start` with both operands present and then holds `mcand` steady. Exactly `WIDTH` cycles after the start is accepted, `done` pulses for one cycle. `product` then holds the result until the next accepted start.

Top module: `lowact_mult`

## Requirements
- R1: A `start` sampled high while the block is idle is accepted at that clock edge. The operation then takes exactly `WIDTH` further edges, and `done` is high during the cycle after the last of them (`done` is first seen `WIDTH+1` falling edges after `start` was driven on a falling edge).
- R2: When `done` is high, `product` equals the unsigned product `mcand * mplier` over all `2*WIDTH` bits. `mcand` sits in the upper half of the adder, and `product[2*WIDTH-1:WIDTH]` is the high word.
- R3: `done` is high for exactly one cycle per accepted start, and never while an operation is still retiring bits.
- R4: A `start` that arrives while an operation is in progress is ignored. The running operation keeps its operands and its timing, and the ring advances one position per cycle.
- R5: Once `done` has been seen, `product` keeps its value on every later cycle until a new start is accepted.
- R6: While the block is busy, the bit-select ring holds exactly one set bit. It sits at position 0 on the first step and moves up by one position each cycle.
- R7: On a cycle whose selected multiplier bit is 0, the upper product half becomes its previous value shifted right by one with a zero fill, and no addition takes place.
- R8: While `rst_n` is low, `done` is 0, `product` is 0 and the block is idle.
- R9: `mcand` is not registered, so the caller must keep it unchanged from the accepting edge until `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously upstream |
| start | input | 1 | Begin an operation when idle |
| mcand | input | WIDTH | Multiplicand; feeds the adder directly and must be held while busy |
| mplier | input | WIDTH | Multiplier; captured when a start is accepted |
| product | output | 2*WIDTH | Full unsigned product |
| done | output | 1 | One-cycle pulse when the product is ready |

## Verification
The assertions check, on every cycle, the properties that follow from the state alone. These are the one-hot ring during an operation, the done pulse following the top ring position, the ignoring of a mid-run start, the zero-bit shift of the upper half, the holding of the product while idle, and the caller holding `mcand` steady. Whether the arithmetic is correct over all operand pairs can only be shown by the bench scenarios. The same holds for the exact latency seen at the ports and for a mid-run start leaving the result unchanged. The bench sweeps every operand pair of a narrow configuration and compares each result with a product it computes itself.

// File: rtl/lam_pkg.sv
package lam_pkg;

  typedef enum logic {
    LAM_IDLE = 1'b0,
    LAM_RUN  = 1'b1
  } lam_state_e;

  localparam int unsigned LAM_DEF_WIDTH = 32;

endpackage

// File: rtl/lam_ctrl.sv
module lam_ctrl
  import lam_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic last_pos,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);

  lam_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    load    = (state_q == LAM_IDLE) && start;
    step    = (state_q == LAM_RUN);
    state_d = state_q;
    done_d  = 1'b0;
    case (state_q)
      LAM_IDLE: if (start) state_d = LAM_RUN;
      LAM_RUN: begin
        if (last_pos) begin
          state_d = LAM_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = LAM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LAM_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign busy = (state_q == LAM_RUN);
  assign done = done_q;

endmodule

// File: rtl/lam_ring.sv
module lam_ring #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  output logic [WIDTH-1:0] ring_q
);

  localparam logic [WIDTH-1:0] FIRST_POS = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] ring_d;
  logic             ring_en;

  always_comb begin
    ring_en = load | step;
    if (load) ring_d = FIRST_POS;
    else      ring_d = {ring_q[WIDTH-2:0], ring_q[WIDTH-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ring_q <= '0;
    else if (ring_en) ring_q <= ring_d;
  end

endmodule

// File: rtl/lam_upper.sv
module lam_upper #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             bit_sel,
  input  logic [WIDTH-1:0] mcand,
  output logic [WIDTH-1:0] hi_q,
  output logic             lsb_out
);

  logic [WIDTH:0]   add_res;
  logic [WIDTH:0]   pass_res;
  logic [WIDTH:0]   sel_res;
  logic [WIDTH-1:0] hi_d;
  logic             hi_en;

  always_comb begin
    add_res  = {1'b0, hi_q} + {1'b0, mcand};
    pass_res = {1'b0, hi_q};
    sel_res  = bit_sel ? add_res : pass_res;
    lsb_out  = sel_res[0];
    hi_en    = clr | step;
    if (clr) hi_d = '0;
    else     hi_d = sel_res[WIDTH:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_en) hi_q <= hi_d;
  end

endmodule

// File: rtl/lam_lower.sv
module lam_lower #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [WIDTH-1:0] ring,
  input  logic             lsb_in,
  output logic [WIDTH-1:0] lo_q
);

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slot
    logic slot_en;
    assign slot_en = step & ring[gi];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lo_q[gi] <= 1'b0;
      else if (slot_en) lo_q[gi] <= lsb_in;
    end
  end

endmodule

// File: rtl/lowact_mult.sv
module lowact_mult #(
  parameter int unsigned WIDTH = lam_pkg::LAM_DEF_WIDTH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] product,
  output logic               done
);

  localparam int unsigned PROD_W = 2 * WIDTH;

  logic             load;
  logic             step;
  logic             busy;
  logic [WIDTH-1:0] ring_q;
  logic [WIDTH-1:0] mplier_q;
  logic [WIDTH-1:0] hi_q;
  logic [WIDTH-1:0] lo_q;
  logic             bit_sel;
  logic             lsb_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mplier_q <= '0;
    else if (load) mplier_q <= mplier;
  end

  assign bit_sel = |(mplier_q & ring_q);

  lam_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .last_pos (ring_q[WIDTH-1]),
    .load     (load),
    .step     (step),
    .busy     (busy),
    .done     (done)
  );

  lam_ring #(.WIDTH(WIDTH)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .step   (step),
    .ring_q (ring_q)
  );

  lam_upper #(.WIDTH(WIDTH)) u_upper (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (load),
    .step    (step),
    .bit_sel (bit_sel),
    .mcand   (mcand),
    .hi_q    (hi_q),
    .lsb_out (lsb_w)
  );

  lam_lower #(.WIDTH(WIDTH)) u_lower (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .ring   (ring_q),
    .lsb_in (lsb_w),
    .lo_q   (lo_q)
  );

  assign product = PROD_W'({hi_q, lo_q});

endmodule

// File: rtl/lowact_mult_chk.sv
module lowact_mult_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               done,
  input logic               busy,
  input logic [WIDTH-1:0]   ring,
  input logic [WIDTH-1:0]   hi,
  input logic               bit_sel,
  input logic [WIDTH-1:0]   mcand,
  input logic [2*WIDTH-1:0] product
);

  localparam logic [WIDTH-1:0] FIRST_POS = {{(WIDTH-1){1'b0}}, 1'b1};

  // R1: an accepted start begins a run at ring position 0
  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && ring == FIRST_POS));

  // R3: done follows the top ring position and lasts one cycle
  a_r3_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ring[WIDTH-1]) |=> (done && !busy));
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4: a start during a run neither restarts nor stalls the ring
  a_r4_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !ring[WIDTH-1]) |=>
      (busy && ring == {$past(ring[WIDTH-2:0]), 1'b0}));

  // R5: product holds while idle and no start arrives
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

  // R6: exactly one selected position while running
  a_r6_ring_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot(ring));

  // R7: zero bit shifts the upper half with a zero fill
  a_r7_zero_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_sel) |=> (hi == ($past(hi) >> 1)));

  // R9: caller keeps the multiplicand steady during a run
  a_r9_mcand_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(mcand));

endmodule

bind lowact_mult lowact_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .done    (done),
  .busy    (busy),
  .ring    (ring_q),
  .hi      (hi_q),
  .bit_sel (bit_sel),
  .mcand   (mcand),
  .product (product)
);

// File: tb/test_lowact_mult.sv
module test_lowact_mult;

  localparam int unsigned W  = 6;
  localparam int unsigned PW = 2 * W;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [W-1:0]  mcand;
  logic [W-1:0]  mplier;
  logic [PW-1:0] product;
  logic          done;

  int n_run;
  int n_fail;

  lowact_mult #(.WIDTH(W)) i_lowact_mult (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .product (product),
    .done    (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one operation; optional mid-run start with another multiplier (R4)
  task automatic run_op(input int a, input int b, input bit poke, input bit full_chk);
    int cyc;
    logic [PW-1:0] expv;
    logic [PW-1:0] held;
    expv = PW'(a * b);
    @(negedge clk);
    mcand  = W'(a);
    mplier = W'(b);
    start  = 1'b1;
    cyc = 0;
    for (int k = 0; k < W + 4; k++) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (poke && cyc == 2) begin
        start  = 1'b1;
        mplier = ~W'(b);
      end
      if (done) break;
    end
    start = 1'b0;
    chk(cyc == W + 1, "R1 latency", cyc, W + 1);
    chk(product == expv, poke ? "R4 result after ignored start" : "R2 product",
        product, expv);
    if (full_chk) begin
      held = product;
      @(negedge clk);
      chk(done == 1'b0, "R3 single pulse", done, 0);
      @(negedge clk);
      @(negedge clk);
      chk(product == held, "R5 product held", product, held);
    end
  endtask

  initial begin
    n_run  = 0;
    n_fail = 0;
    start  = 1'b0;
    mcand  = '0;
    mplier = '0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R8 done in reset", done, 0);
    chk(product == '0, "R8 product in reset", product, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R8 done after reset", done, 0);

    // R2 R6 R7: exhaustive sweep, zero / all-ones / single-bit included
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        run_op(a, b, 1'b0, (a % 9 == 0) && (b % 7 == 0));
      end
    end

    // R4: start during a run is ignored
    run_op((1 << W) - 1, 5, 1'b1, 1'b1);
    run_op(1, (1 << W) - 1, 1'b1, 1'b1);
    run_op(37, 0, 1'b1, 1'b1);

    // R3: back-to-back start right after done
    run_op(1 << (W - 1), 1 << (W - 1), 1'b0, 1'b0);
    run_op(3, 3, 1'b0, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule